// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one full 256-byte page from processor address space into sprite attribute memory. A single trigger starts the copy and carries the page number. The source address is formed by putting the page number in the upper byte and a running byte offset in the lower byte. While the copy runs, the block holds the processor stalled. It issues one bus read per byte and writes each byte to the sprite data port. That port advances its own 8-bit pointer after every write, so the block never drives a sprite address.

Before the first read, the block waits one or two alignment cycles. The count depends on the parity of the processor cycle in which the trigger was accepted. After that, every byte takes exactly two cycles: a read cycle, then a write cycle. One cycle after the final write, a single-cycle completion pulse is raised and the stall is dropped.

Top module: `spr_page_copier`

## Requirements
- R1: The bus address during a read cycle is the latched page number in bits 15:8 and the byte offset in bits 7:0.
- R2: A trigger accepted while `cpu_odd_i` is 1 is followed by exactly one alignment cycle, so stall lasts 513 cycles.
- R3: A trigger accepted while `cpu_odd_i` is 0 is followed by exactly two alignment cycles, so stall lasts 514 cycles.
- R4: Reads cover offsets 0 through 255 in ascending order, each exactly once.
- R5: Every read cycle is followed immediately by a write cycle, and the write data equals the read data returned during that read cycle.
- R6: Exactly 256 write strobes are issued per transfer, and stall is high in every cycle from the one after the trigger through the final write cycle.
- R7: `done_o` is high for exactly one cycle, in the cycle right after the final write, and stall is low in that cycle.
- R8: A trigger that arrives while a transfer is running is ignored: the page is not re-latched and the transfer is not restarted or lengthened.
- R9: A trigger presented in the cycle that `done_o` is high is accepted and starts a new transfer.
- R10: After reset, stall, read strobe, write strobe and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start request, sampled when idle |
| page_i | input | 8 | Source page number, latched with an accepted trigger |
| cpu_odd_i | input | 1 | 1 when the current processor cycle is odd |
| rdata_i | input | 8 | Bus read data, valid in the read cycle |
| stall_o | output | 1 | Holds the processor while a copy runs |
| bus_addr_o | output | 16 | Source address for the bus read |
| bus_rd_o | output | 1 | Bus read strobe |
| spr_wdata_o | output | 8 | Data for the sprite data port |
| spr_wr_o | output | 1 | Sprite data port write strobe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Completion and a fresh start can fall in the same cycle. The bench watches for `done_o` at the falling edge and raises a new trigger with a different page and parity in that same cycle. The scoreboard then requires an unbroken new transfer with the right addresses and the exact 513- or 514-cycle stall. The opposite overlap, a trigger landing during alignment or mid-copy, is judged by the same scoreboard. It must see no re-latched page, no extra reads and no change in stall length.

// File: rtl/spr_copy_pkg.sv
package spr_copy_pkg;

    localparam int PAGE_W_DEF = 8;
    localparam int OFFS_W_DEF = 8;
    localparam int DATA_W_DEF = 8;

    // Odd parity needs one alignment cycle, even needs two.
    localparam int ALIGN_ODD  = 1;
    localparam int ALIGN_EVEN = 2;
    localparam int ALIGN_W    = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    function automatic logic [ALIGN_W-1:0] align_len(input logic odd);
        return odd ? ALIGN_W'(ALIGN_ODD) : ALIGN_W'(ALIGN_EVEN);
    endfunction

    function automatic logic is_busy(input phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/spr_copy_seq.sv
module spr_copy_seq
    import spr_copy_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   odd_i,
    input  logic   last_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   done_o
);

    phase_e               phase_q;
    logic [ALIGN_W-1:0]   align_q;
    logic                 done_q;

    assign accept_o = (phase_q == PH_IDLE) && start_i;
    assign phase_o  = phase_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            align_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_ALIGN;
                        align_q <= align_len(odd_i);
                    end
                end
                PH_ALIGN: begin
                    if (align_q == ALIGN_W'(1)) begin
                        phase_q <= PH_READ;
                    end else begin
                        align_q <= align_q - ALIGN_W'(1);
                    end
                end
                PH_READ: begin
                    phase_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    if (last_i) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_READ;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_odd_align_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start_i && odd_i) |=> (phase_q == PH_ALIGN) ##1 (phase_q == PH_READ));

    assert_even_align_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start_i && !odd_i)
            |=> (phase_q == PH_ALIGN) ##1 (phase_q == PH_ALIGN) ##1 (phase_q == PH_READ));

    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ) |=> (phase_q == PH_WRITE));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(phase_q) == PH_WRITE && phase_q == PH_IDLE));

    assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ || phase_q == PH_WRITE) |=> (phase_q != PH_ALIGN));

endmodule

// File: rtl/spr_copy_addr.sv
module spr_copy_addr
    import spr_copy_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int OFFS_W = OFFS_W_DEF,
    localparam int ADDR_W = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [PAGE_W-1:0] page_i,
    input  phase_e            phase_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam logic [OFFS_W-1:0] OFFS_LAST = {OFFS_W{1'b1}};

    logic [PAGE_W-1:0] page_q;
    logic [OFFS_W-1:0] offs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            offs_q <= '0;
        end else if (accept_i) begin
            page_q <= page_i;
            offs_q <= '0;
        end else if (phase_i == PH_WRITE) begin
            offs_q <= offs_q + OFFS_W'(1);
        end
    end

    assign addr_o = {page_q, offs_q};
    assign last_o = (offs_q == OFFS_LAST);

    assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_READ && $past(phase_i) == PH_WRITE) |-> (offs_q == $past(offs_q) + OFFS_W'(1)));

    assert_first_offset_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_READ && $past(phase_i) == PH_ALIGN) |-> (offs_q == '0));

    assert_page_held_R8: assert property (@(posedge clk) disable iff (rst)
        is_busy(phase_i) |=> $stable(page_q));

endmodule

// File: rtl/spr_copy_wport.sv
module spr_copy_wport
    import spr_copy_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              rd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o
);

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (phase_i == PH_READ) begin
            hold_q <= rdata_i;
        end
    end

    assign rd_o    = (phase_i == PH_READ);
    assign wr_o    = (phase_i == PH_WRITE);
    assign wdata_o = hold_q;

    assert_write_data_R5: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> (wr_o && wdata_o == $past(rdata_i)));

endmodule

// File: rtl/spr_page_copier.sv
module spr_page_copier
    import spr_copy_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int OFFS_W = OFFS_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int ADDR_W = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              cpu_odd_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              stall_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic [DATA_W-1:0] spr_wdata_o,
    output logic              spr_wr_o,
    output logic              done_o
);

    phase_e phase;
    logic   accept;
    logic   last;

    spr_copy_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (trig_i),
        .odd_i    (cpu_odd_i),
        .last_i   (last),
        .phase_o  (phase),
        .accept_o (accept),
        .done_o   (done_o)
    );

    spr_copy_addr #(
        .PAGE_W (PAGE_W),
        .OFFS_W (OFFS_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .page_i   (page_i),
        .phase_i  (phase),
        .addr_o   (bus_addr_o),
        .last_o   (last)
    );

    spr_copy_wport #(
        .DATA_W (DATA_W)
    ) u_wport (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase),
        .rdata_i (rdata_i),
        .rd_o    (bus_rd_o),
        .wr_o    (spr_wr_o),
        .wdata_o (spr_wdata_o)
    );

    assign stall_o = is_busy(phase);

    assert_stall_start_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && trig_i) |=> stall_o);

    assert_done_unstalled_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !stall_o);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_rd_o, spr_wr_o, done_o}));

endmodule

// File: tb/test_spr_page_copier.sv
module test_spr_page_copier;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [7:0]  page = '0;
    logic        odd = 1'b0;
    logic [7:0]  rdata;
    logic        stall;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  wdata;
    logic        wr;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;

    beat_t exp_q[$];
    int    len_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
    endfunction

    assign rdata = mem_byte(bus_addr);

    spr_page_copier i_spr_page_copier (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig),
        .page_i      (page),
        .cpu_odd_i   (odd),
        .rdata_i     (rdata),
        .stall_o     (stall),
        .bus_addr_o  (bus_addr),
        .bus_rd_o    (bus_rd),
        .spr_wdata_o (wdata),
        .spr_wr_o    (wr),
        .done_o      (done)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the trigger is sampled at the next rising edge.
    task automatic launch(input logic [7:0] pg, input logic par, input logic expect_run);
        trig = 1'b1;
        page = pg;
        odd  = par;
        if (expect_run) begin
            for (int i = 0; i < 256; i++) begin
                beat_t b;
                b.addr = {pg, 8'(i)};
                b.data = mem_byte(b.addr);
                exp_q.push_back(b);
            end
            len_q.push_back(par ? 513 : 514);
        end
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Monitor / scoreboard
    int    stall_run = 0;
    int    wr_count  = 0;
    logic  prev_rd   = 1'b0;
    logic  prev_wr   = 1'b0;
    beat_t cur;

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst) begin
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected read", 1'b0, bus_addr, 0);
                end else begin
                    cur = exp_q[0];
                    check("R1/R4 read address", bus_addr == cur.addr, bus_addr, cur.addr);
                end
            end
            if (prev_rd) begin
                check("R5 write follows read", wr, wr, 1);
            end
            if (wr) begin
                if (exp_q.size() != 0) begin
                    cur = exp_q.pop_front();
                    check("R5 write data", wdata == cur.data, wdata, cur.data);
                end
                wr_count++;
            end
            if (stall) stall_run++;
            if (done) begin
                check("R7 stall low with done", !stall, stall, 0);
                check("R7 done after last write", prev_wr, prev_wr, 1);
                check("R6 write count", wr_count == 256, wr_count, 256);
                if (len_q.size() == 0) begin
                    check("R8 unexpected completion", 1'b0, stall_run, 0);
                end else begin
                    int el;
                    el = len_q.pop_front();
                    check(el == 513 ? "R2 stall length" : "R3 stall length",
                          stall_run == el, stall_run, el);
                end
                stall_run = 0;
                wr_count  = 0;
            end
            prev_rd = bus_rd;
            prev_wr = wr;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 stall after reset", !stall, stall, 0);
        check("R10 read strobe after reset", !bus_rd, bus_rd, 0);
        check("R10 write strobe after reset", !wr, wr, 0);
        check("R10 done after reset", !done, done, 0);

        // Odd parity copy, with a mid-run trigger that must be ignored (R8)
        launch(8'h02, 1'b1, 1'b1);
        repeat (100) @(negedge clk);
        launch(8'hC7, 1'b0, 1'b0);
        wait_done();

        // R9: new trigger in the done cycle, even parity, top page
        launch(8'hFF, 1'b0, 1'b1);
        // Trigger during alignment must be ignored (R8)
        launch(8'h33, 1'b1, 1'b0);
        wait_done();
        @(negedge clk);

        repeat (5) @(negedge clk);
        check("R6 idle between copies", !stall, stall, 0);
        launch(8'h00, 1'b0, 1'b1);
        wait_done();
        @(negedge clk);
        repeat (3) @(negedge clk);
        launch(8'h80, 1'b1, 1'b1);
        wait_done();
        @(negedge clk);
        repeat (4) @(negedge clk);

        check("R8 no leftover reads", exp_q.size() == 0, exp_q.size(), 0);
        check("R8 no leftover runs", len_q.size() == 0, len_q.size(), 0);
        check("R7 idle after final done", !stall && !done, {stall, done}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule